// File: doc/BRIEF.md
# Auto-Reload Down-Counter with Input Capture

This block is one timer channel. A down counter decrements by one on each count step
while the run bit is set. A step comes either from an internal prescaled enable pulse or
from a selected edge of an external event input. When a step arrives with the counter
already at zero, the counter is loaded from a reload register instead of wrapping. The
same step sets a sticky underflow flag that can raise an interrupt, and counting carries
on with no pause, so the channel runs in a repeating cycle.

A separate capture input, synchronised and edge-selected, copies the live counter value
into a read-only capture register. Capture also sets a capture flag, and no further
capture is taken until software clears that flag. The capture register has no reset, so
a captured value survives a reset of the block. Software reaches all registers through a
simple word-wide read/write port. A read returns its data one cycle after the request.

Top module: `reload_down_timer`

## Requirements
- R1: Register addresses are 0 = control, 1 = counter, 2 = reload, 3 = capture. After reset, control, counter and reload read as 0 and `irq` is 0. Each read request returns `rdata` with `rd_valid` high one cycle later.
- R2: The counter changes only on a count step while control bit 0 (run) is 1. A step is a `tick_en` pulse when control bit 1 (source) is 0, or the selected edge of `evt_in` when bit 1 is 1. With the source bit set, `tick_en` has no effect.
- R3: A count step with a counter value other than zero lowers the counter by exactly one.
- R4: A count step with the counter at zero loads the reload value, sets the underflow flag (control bit 9), and leaves counting running.
- R5: `irq` is high while (underflow flag AND control bit 7) OR (capture flag AND control bit 8).
- R6: Both flags are sticky. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. A flag set by hardware in the same cycle as a clearing write stays set.
- R7: When control bit 4 (capture enable) is 1, the capture flag (bit 10) is 0 and the selected `cap_in` edge arrives, the counter value is copied to the capture register and the capture flag sets. While the flag is 1, or the enable bit is 0, capture edges are ignored.
- R8: Reset does not change the capture register.
- R9: A software write to the counter in the same cycle as an underflow reload loads the written value. The underflow flag still sets.
- R10: Edge selects are control bits 3:2 for `evt_in` and bits 6:5 for `cap_in`, with the code 00 none, 01 rising, 10 falling, 11 both. Each input passes through two synchroniser flops before edge detection.
- R11: Writes to the capture address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Internal prescaled count enable |
| evt_in | input | 1 | External event input (asynchronous) |
| cap_in | input | 1 | Capture trigger input (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| irq | output | 1 | Interrupt request |

## Verification
Two events can fall in the same cycle: the underflow reload and a software write to the counter. A sticky flag being set by hardware can also coincide with software clearing it. The bench brings the counter to zero and then, in one cycle, raises `tick_en` together with a write to the counter, and separately together with a flag-clearing control write. It judges the result by reading back both the counter and the flag. The write must win the counter, and the hardware set must win the flag.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL    = 2'd0;
    localparam logic [ADDR_W-1:0] A_COUNT   = 2'd1;
    localparam logic [ADDR_W-1:0] A_RELOAD  = 2'd2;
    localparam logic [ADDR_W-1:0] A_CAPTURE = 2'd3;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_t;

    // control word, MSB first: bit 10 down to bit 0
    typedef struct packed {
        logic      cap_flag;   // 10
        logic      unf_flag;   // 9
        logic      cap_ie;     // 8
        logic      unf_ie;     // 7
        edge_sel_t cap_edge;   // 6:5
        logic      cap_en;     // 4
        edge_sel_t evt_edge;   // 3:2
        logic      src_ext;    // 1
        logic      run;        // 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/rdt_edge_det.sv
module rdt_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig_i,
    input  logic [1:0] sel_i,
    output logic       pulse_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } det_t;

    det_t st_d, st_q;
    logic cur;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], sig_i};
        st_d.prev = st_q.sync[SYNC_STAGES-1];
        cur       = st_q.sync[SYNC_STAGES-1];
        pulse_o   = (sel_i[0] & cur & ~st_q.prev) | (sel_i[1] & ~cur & st_q.prev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rdt_count_next.sv
module rdt_count_next #(
    parameter int W = 32
) (
    input  logic [W-1:0] cnt_q,
    input  logic [W-1:0] reload_q,
    input  logic         step,
    input  logic         sw_wr,
    input  logic [W-1:0] sw_val,
    output logic [W-1:0] cnt_d,
    output logic         unf
);
    always_comb begin
        unf = step && (cnt_q == '0);
        if (sw_wr)     cnt_d = sw_val;
        else if (unf)  cnt_d = reload_q;
        else if (step) cnt_d = cnt_q - 1'b1;
        else           cnt_d = cnt_q;
    end
endmodule

// File: rtl/reload_down_timer.sv
module reload_down_timer
    import rdt_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              evt_in,
    input  logic              cap_in,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              rd_valid,
    output logic              irq
);
    localparam int N_DET = 2;   // 0: event input, 1: capture input

    typedef struct packed {
        ctrl_t             ctrl;
        logic [CNT_W-1:0]  count;
        logic [CNT_W-1:0]  reload;
        logic [CNT_W-1:0]  rdata;
        logic              rd_valid;
    } state_t;

    state_t st_d, st_q;
    logic [CNT_W-1:0] capture_q;

    logic [N_DET-1:0]      det_in;
    logic [N_DET-1:0][1:0] det_sel;
    logic [N_DET-1:0]      det_pulse;

    logic             wr_ctrl, wr_cnt, wr_reload;
    logic             step, unf, cap_hit;
    logic [CNT_W-1:0] cnt_next;
    ctrl_t            wr_word;

    assign det_in[0]  = evt_in;
    assign det_in[1]  = cap_in;
    assign det_sel[0] = st_q.ctrl.evt_edge;
    assign det_sel[1] = st_q.ctrl.cap_edge;

    for (genvar i = 0; i < N_DET; i++) begin : g_det
        rdt_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .sig_i   (det_in[i]),
            .sel_i   (det_sel[i]),
            .pulse_o (det_pulse[i])
        );
    end

    assign wr_ctrl   = wr_en && (addr == A_CTRL);
    assign wr_cnt    = wr_en && (addr == A_COUNT);
    assign wr_reload = wr_en && (addr == A_RELOAD);

    assign step    = st_q.ctrl.run && (st_q.ctrl.src_ext ? det_pulse[0] : tick_en);
    assign cap_hit = det_pulse[1] && st_q.ctrl.cap_en && !st_q.ctrl.cap_flag;

    rdt_count_next #(.W(CNT_W)) u_next (
        .cnt_q    (st_q.count),
        .reload_q (st_q.reload),
        .step     (step),
        .sw_wr    (wr_cnt),
        .sw_val   (wdata),
        .cnt_d    (cnt_next),
        .unf      (unf)
    );

    always_comb begin
        st_d    = st_q;
        wr_word = ctrl_t'(wdata[CTRL_W-1:0]);

        if (wr_ctrl) begin
            st_d.ctrl          = wr_word;
            st_d.ctrl.unf_flag = st_q.ctrl.unf_flag & wr_word.unf_flag;
            st_d.ctrl.cap_flag = st_q.ctrl.cap_flag & wr_word.cap_flag;
        end
        if (unf)     st_d.ctrl.unf_flag = 1'b1;
        if (cap_hit) st_d.ctrl.cap_flag = 1'b1;

        st_d.count = cnt_next;
        if (wr_reload) st_d.reload = wdata;

        st_d.rd_valid = rd_en;
        if (rd_en) begin
            case (addr)
                A_CTRL:   st_d.rdata = {{(CNT_W-CTRL_W){1'b0}}, st_q.ctrl};
                A_COUNT:  st_d.rdata = st_q.count;
                A_RELOAD: st_d.rdata = st_q.reload;
                default:  st_d.rdata = capture_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // capture holder deliberately has no reset
    always_ff @(posedge clk) begin
        if (rst_n && cap_hit) capture_q <= st_q.count;
    end

    assign rdata    = st_q.rdata;
    assign rd_valid = st_q.rd_valid;
    assign irq      = (st_q.ctrl.unf_flag & st_q.ctrl.unf_ie) |
                      (st_q.ctrl.cap_flag & st_q.ctrl.cap_ie);
endmodule

// File: rtl/rdt_checker.sv
module rdt_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic [W-1:0] count,
    input logic [W-1:0] reload,
    input logic         step,
    input logic         cnt_wr,
    input logic         ctrl_wr,
    input logic [W-1:0] wdata,
    input logic         unf_flag,
    input logic         unf_ie,
    input logic         cap_flag,
    input logic [W-1:0] capture,
    input logic         irq
);
    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(count)); // R2

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (step && count != '0 && !cnt_wr) |=> (count == $past(count) - 1'b1)); // R3

    AST_UNF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && count == '0 && !cnt_wr) |=> (count == $past(reload))); // R4

    AST_UNF_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (step && count == '0) |=> unf_flag); // R4

    AST_IRQ_ON_UNF: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(unf_flag) && unf_ie) |-> irq); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_flag && !ctrl_wr) |=> unf_flag); // R6

    AST_CAP_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        cap_flag |=> $stable(capture)); // R7

    AST_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count == $past(wdata))); // R9
endmodule

bind reload_down_timer rdt_checker #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (st_q.ctrl.run),
    .count    (st_q.count),
    .reload   (st_q.reload),
    .step     (step),
    .cnt_wr   (wr_cnt),
    .ctrl_wr  (wr_ctrl),
    .wdata    (wdata),
    .unf_flag (st_q.ctrl.unf_flag),
    .unf_ie   (st_q.ctrl.unf_ie),
    .cap_flag (st_q.ctrl.cap_flag),
    .capture  (capture_q),
    .irq      (irq)
);

// File: tb/reload_down_timer_bench.sv
`timescale 1ns/1ps
module reload_down_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0, evt_in = 1'b0, cap_in = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rd_valid, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    reload_down_timer u_reload_down_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .evt_in(evt_in), .cap_in(cap_in),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rd_valid(rd_valid), .irq(irq)
    );

    // monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (rd_valid) begin
            logic [31:0] e;
            string       t;
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL unexpected read: got %h expected none", rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h", t, rdata, e);
                end
            end
        end
    end

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk); addr = a; wdata = v; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, input logic [31:0] e, input string t);
        @(negedge clk); addr = a; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        checks++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s: irq got %b expected %b", t, irq, e);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic set_evt(input logic v);
        @(negedge clk); evt_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_cap(input logic v);
        @(negedge clk); cap_in = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_rd(2'd0, 32'h0, "R1 ctrl after reset");
        reg_rd(2'd1, 32'h0, "R1 count after reset");
        reg_rd(2'd2, 32'h0, "R1 reload after reset");
        chk_irq(1'b0, "R1 irq after reset");

        // R2 stopped counter ignores ticks
        reg_wr(2'd2, 32'd3);
        reg_wr(2'd1, 32'd2);
        reg_wr(2'd0, 32'h080);
        ticks(3);
        reg_rd(2'd1, 32'd2, "R2 stopped counter");

        // R3 / R4 counting and underflow reload
        reg_wr(2'd0, 32'h081);
        ticks(2);
        reg_rd(2'd1, 32'd0, "R3 decrement to zero");
        chk_irq(1'b0, "R5 no irq before underflow");
        ticks(1);
        reg_rd(2'd1, 32'd3, "R4 reload on underflow");
        reg_rd(2'd0, 32'h281, "R4 underflow flag set");
        chk_irq(1'b1, "R5 irq on underflow");
        ticks(1);
        reg_rd(2'd1, 32'd2, "R4 counting continues");

        // R6 flag write semantics
        reg_wr(2'd0, 32'h681);
        reg_rd(2'd0, 32'h281, "R6 write 1 keeps flag");
        reg_wr(2'd0, 32'h081);
        reg_rd(2'd0, 32'h081, "R6 write 0 clears flag");
        chk_irq(1'b0, "R6 irq drops after clear");

        // R5 masked interrupt
        reg_wr(2'd0, 32'h001);
        ticks(3);
        reg_rd(2'd0, 32'h201, "R5 flag sets with enable off");
        chk_irq(1'b0, "R5 masked irq");
        reg_wr(2'd0, 32'h001);

        // R9 software write vs reload in same cycle
        ticks(3);
        reg_rd(2'd1, 32'd0, "R9 setup count zero");
        @(negedge clk); addr = 2'd1; wdata = 32'd100; wr_en = 1'b1; tick_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; tick_en = 1'b0;
        reg_rd(2'd1, 32'd100, "R9 software write wins");
        reg_rd(2'd0, 32'h201, "R9 underflow still flagged");
        reg_wr(2'd0, 32'h001);

        // R6 hardware set beats clearing write
        reg_wr(2'd1, 32'd0);
        @(negedge clk); addr = 2'd0; wdata = 32'h001; wr_en = 1'b1; tick_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; tick_en = 1'b0;
        reg_rd(2'd0, 32'h201, "R6 set wins over clear");
        reg_rd(2'd1, 32'd3, "R4 reload in collision cycle");
        reg_wr(2'd0, 32'h001);

        // R2 / R10 external event counting
        reg_wr(2'd1, 32'd10);
        reg_wr(2'd0, 32'h007);
        ticks(3);
        reg_rd(2'd1, 32'd10, "R2 tick ignored in external mode");
        set_evt(1'b1);
        reg_rd(2'd1, 32'd9, "R10 rising edge counts");
        set_evt(1'b0);
        reg_rd(2'd1, 32'd9, "R10 falling ignored with rising select");
        reg_wr(2'd0, 32'h00B);
        set_evt(1'b1);
        reg_rd(2'd1, 32'd9, "R10 rising ignored with falling select");
        set_evt(1'b0);
        reg_rd(2'd1, 32'd8, "R10 falling edge counts");
        reg_wr(2'd0, 32'h00F);
        set_evt(1'b1);
        set_evt(1'b0);
        reg_rd(2'd1, 32'd6, "R10 both edges count");
        reg_wr(2'd0, 32'h003);
        set_evt(1'b1);
        set_evt(1'b0);
        reg_rd(2'd1, 32'd6, "R10 no edge select");

        // R7 capture and lockout
        reg_wr(2'd0, 32'h130);
        reg_wr(2'd1, 32'd50);
        set_cap(1'b1);
        reg_rd(2'd3, 32'd50, "R7 capture value");
        reg_rd(2'd0, 32'h530, "R7 capture flag set");
        chk_irq(1'b1, "R5 irq on capture");
        set_cap(1'b0);
        reg_wr(2'd1, 32'd40);
        set_cap(1'b1);
        reg_rd(2'd3, 32'd50, "R7 lockout while flag set");
        reg_wr(2'd3, 32'd77);
        reg_rd(2'd3, 32'd50, "R11 capture write ignored");
        reg_wr(2'd0, 32'h150);
        set_cap(1'b0);
        reg_rd(2'd3, 32'd40, "R7 falling-edge capture after clear");
        reg_rd(2'd0, 32'h550, "R7 flag set again");
        reg_wr(2'd0, 32'h140);
        reg_wr(2'd1, 32'd33);
        set_cap(1'b1);
        set_cap(1'b0);
        reg_rd(2'd3, 32'd40, "R7 disabled capture ignored");
        reg_rd(2'd0, 32'h140, "R7 no flag when disabled");

        // R8 capture survives reset
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        reg_rd(2'd3, 32'd40, "R8 capture kept through reset");
        reg_rd(2'd0, 32'h0, "R1 ctrl cleared by reset");

        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule